// File: doc/BRIEF.md
# I2C Register-File Target

This block is an I2C target that holds a small bank of byte-wide registers and behaves like a tiny serial EEPROM. It watches open-drain SCL and SDA lines, synchronises them into the system clock, and answers one 7-bit device address presented on an input port. Within every addressed transaction, the first byte written is taken as a register pointer. Bytes written after it land in consecutive registers. Bytes read are fetched from consecutive registers.

Each address match rewinds the working position to the stored pointer. A controller can therefore set the pointer, issue a repeated START and read back from that same spot. Positions at or beyond the implemented register count are a dead zone: writes there are dropped and reads there return zero. The whole bank is visible on a flat parallel output for local logic. Bit 0 of register 0 also drives an active-low indicator pin.

Top module: `i2c_regfile_target`

## Requirements
- R1: During and after reset every register reads 0x00, SDA is released (`sda_oe_o` = 0) and `led_n_o` is 1.
- R2: The target pulls SDA low in the ninth clock of an address byte only when bits 7..1 of that byte equal `dev_addr_i`. Otherwise it leaves SDA released and ignores the rest of the transaction. Bit 0 of the address byte selects the direction (0 write, 1 read).
- R3: The first byte written after an address match is stored as the pointer, is acknowledged, and changes no register.
- R4: Each further written byte goes to register `position` (register k occupies `regs_o[8k+7:8k]`), is acknowledged, and then the position increments.
- R5: A written byte whose position is at or beyond NREG is acknowledged but discarded, and the position stays where it is.
- R6: In a read, each byte is sent MSB first from register `position`, and the position then increments.
- R7: A read at a position at or beyond NREG returns 0x00 and leaves the position unchanged.
- R8: Every address match, including one after a repeated START, reloads the position from the last stored pointer.
- R9: When the controller NACKs a read byte, the target stops driving SDA until the next START or STOP.
- R10: A STOP or START arriving inside a byte aborts that byte with no register change, and a START always releases SDA.
- R11: `led_n_o` is 0 exactly when bit 0 of register 0 is 1.
- R12: The target changes its SDA drive only while SCL is low, and it only ever pulls SDA low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dev_addr_i | input | 7 | Device address to answer |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| regs_o | output | NREG*8 | Flattened register bank, register k at bits 8k+7..8k |
| led_n_o | output | 1 | Active-low indicator from bit 0 of register 0 |

## Verification
On every cycle the assertions check four things: SDA drive changes only happen with SCL low, registers change only after a byte strobe, a strobe in the dead zone leaves the bank untouched, and an address match reloads the position from the stored pointer. They also check that reads advance the position and that a START leaves SDA released. Whole-transaction behaviour can only be shown by the bench's scenarios, compared against its reference model. That covers the acknowledge pattern of foreign versus own addresses, the write-pointer, repeated-START and read-back sequence, zero fill past the bank, aborted partial bytes, and silence after a controller NACK.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_RX,
    ST_TX,
    ST_MACK,
    ST_MFALL,
    ST_WAIT
  } tgt_state_e;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s, sda_s;

  generate
    if (STAGES > 1) begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[LAST-1:0], scl_i};
          sda_ff <= {sda_ff[LAST-1:0], sda_i};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
      end
    end
  endgenerate

  assign scl_s = scl_ff[LAST];
  assign sda_s = sda_ff[LAST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_rf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [6:0] dev_addr_i,
  input  logic       sda_s_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [7:0] rd_data_i,
  output logic       sda_oe_o,
  output logic       match_o,
  output logic       wr_o,
  output logic [7:0] wr_data_o,
  output logic       rd_adv_o
);
  tgt_state_e st_q, st_d;
  logic [2:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d;
  logic       dir_q, dir_d;
  logic       ack_q, ack_d;
  logic       oe_q, oe_d;
  logic [7:0] byte_in;

  assign byte_in   = {sh_q[6:0], sda_s_i};
  assign wr_data_o = byte_in;
  assign sda_oe_o  = oe_q;

  always_comb begin
    st_d    = st_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    dir_d   = dir_q;
    ack_d   = ack_q;
    oe_d    = oe_q;
    match_o = 1'b0;
    wr_o    = 1'b0;
    rd_adv_o = 1'b0;
    if (stop_i) begin
      st_d  = ST_IDLE;
      oe_d  = 1'b0;
      ack_d = 1'b0;
    end else if (start_i) begin
      st_d  = ST_ADDR;
      bit_d = '0;
      oe_d  = 1'b0;
      ack_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR, ST_RX: begin
          if (scl_rise_i) begin
            sh_d  = byte_in;
            bit_d = bit_q + 3'd1;
            if (bit_q == 3'd7) begin
              bit_d = '0;
              if (st_q == ST_ADDR) begin
                if (byte_in[7:1] == dev_addr_i) begin
                  match_o = 1'b1;
                  dir_d   = byte_in[0];
                  st_d    = ST_ACK;
                end else begin
                  st_d = ST_WAIT;
                end
              end else begin
                wr_o = 1'b1;
                st_d = ST_ACK;
              end
            end
          end
        end
        ST_ACK: begin
          if (scl_fall_i) begin
            if (!ack_q) begin
              ack_d = 1'b1;
              oe_d  = 1'b1;
            end else begin
              ack_d = 1'b0;
              bit_d = '0;
              if (dir_q) begin
                sh_d     = rd_data_i;
                rd_adv_o = 1'b1;
                oe_d     = ~rd_data_i[7];
                st_d     = ST_TX;
              end else begin
                oe_d = 1'b0;
                st_d = ST_RX;
              end
            end
          end
        end
        ST_TX: begin
          if (scl_fall_i) begin
            if (bit_q == 3'd7) begin
              oe_d  = 1'b0;
              bit_d = '0;
              st_d  = ST_MACK;
            end else begin
              sh_d  = {sh_q[6:0], 1'b0};
              oe_d  = ~sh_q[6];
              bit_d = bit_q + 3'd1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise_i) st_d = sda_s_i ? ST_WAIT : ST_MFALL;
        end
        ST_MFALL: begin
          if (scl_fall_i) begin
            sh_d     = rd_data_i;
            rd_adv_o = 1'b1;
            oe_d     = ~rd_data_i[7];
            bit_d    = '0;
            st_d     = ST_TX;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      bit_q <= '0;
      sh_q  <= '0;
      dir_q <= 1'b0;
      ack_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
      dir_q <= dir_d;
      ack_q <= ack_d;
      oe_q  <= oe_d;
    end
  end
endmodule

// File: rtl/regfile_bank.sv
module regfile_bank #(
  parameter int NREG = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              match_i,
  input  logic              wr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              rd_adv_i,
  output logic [7:0]        rd_data_o,
  output logic [NREG*8-1:0] regs_o
);
  localparam logic [8:0] LIMIT = 9'(NREG);

  logic [7:0] off_q, pos_q;
  logic       first_q;
  logic       in_range;

  assign in_range = {1'b0, pos_q} < LIMIT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q   <= '0;
      pos_q   <= '0;
      first_q <= 1'b1;
    end else if (match_i) begin
      first_q <= 1'b1;
      pos_q   <= off_q;
    end else if (wr_i) begin
      if (first_q) begin
        off_q   <= wr_data_i;
        pos_q   <= wr_data_i;
        first_q <= 1'b0;
      end else if (in_range) begin
        pos_q <= pos_q + 8'd1;
      end
    end else if (rd_adv_i && in_range) begin
      pos_q <= pos_q + 8'd1;
    end
  end

  generate
    for (genvar k = 0; k < NREG; k++) begin : g_cell
      logic [7:0] cell_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cell_q <= '0;
        else if (wr_i && !match_i && !first_q && pos_q == 8'(k)) cell_q <= wr_data_i;
      end
      assign regs_o[k*8 +: 8] = cell_q;
    end
  endgenerate

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < NREG; k++) begin
      if (pos_q == 8'(k)) rd_data_o = regs_o[k*8 +: 8];
    end
  end
endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target #(
  parameter int NREG        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [6:0]        dev_addr_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [NREG*8-1:0] regs_o,
  output logic              led_n_o
);
  logic       sda_s, scl_rise, scl_fall, start, stop;
  logic       match, wr_stb, rd_adv;
  logic [7:0] wr_data, rd_data;

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start),
    .stop_o     (stop)
  );

  i2c_target_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dev_addr_i (dev_addr_i),
    .sda_s_i    (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start),
    .stop_i     (stop),
    .rd_data_i  (rd_data),
    .sda_oe_o   (sda_oe_o),
    .match_o    (match),
    .wr_o       (wr_stb),
    .wr_data_o  (wr_data),
    .rd_adv_o   (rd_adv)
  );

  regfile_bank #(.NREG(NREG)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .match_i   (match),
    .wr_i      (wr_stb),
    .wr_data_i (wr_data),
    .rd_adv_i  (rd_adv),
    .rd_data_o (rd_data),
    .regs_o    (regs_o)
  );

  assign led_n_o = ~regs_o[0];
endmodule

// File: rtl/i2c_regfile_target_chk.sv
module i2c_regfile_target_chk #(
  parameter int NREG = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_i,
  input logic              sda_oe_o,
  input logic [NREG*8-1:0] regs_o,
  input logic              wr_stb,
  input logic              match,
  input logic              rd_adv,
  input logic              start,
  input logic [7:0]        pos,
  input logic [7:0]        off,
  input logic              first
);
  localparam logic [8:0] LIMIT = 9'(NREG);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r1: assert (!sda_oe_o && regs_o == '0);
    end
  end

  p_sda_moves_scl_low_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);

  p_regs_need_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(regs_o) |-> $past(wr_stb));

  p_dead_zone_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb && !first && ({1'b0, pos} >= LIMIT)) |=> $stable(regs_o));

  p_match_rewind_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match |=> pos == $past(off));

  p_read_advance_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_adv && ({1'b0, pos} < LIMIT)) |=> pos == $past(pos) + 8'd1);

  p_start_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> !sda_oe_o);
endmodule

bind i2c_regfile_target i2c_regfile_target_chk #(.NREG(NREG)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_i    (scl_i),
  .sda_oe_o (sda_oe_o),
  .regs_o   (regs_o),
  .wr_stb   (wr_stb),
  .match    (match),
  .rd_adv   (rd_adv),
  .start    (start),
  .pos      (u_bank.pos_q),
  .off      (u_bank.off_q),
  .first    (u_bank.first_q)
);

// File: tb/tb_i2c_regfile_target.sv
module tb_i2c_regfile_target;
  localparam int N = 8;
  localparam int Q = 8;
  localparam logic [6:0] DEV = 7'h29;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_c = 1'b1;
  logic sda_c = 1'b1;
  logic hold = 1'b0;
  logic sda_oe;
  logic led_n;
  logic [N*8-1:0] regs;
  logic sda_line;

  int total = 0;
  int bad = 0;

  logic [7:0] m_reg [N];
  int m_off = 0;
  int m_pos = 0;
  bit m_first = 1;
  bit m_sel = 0;
  logic prev_oe = 1'b0;

  always #2 clk = ~clk;

  assign sda_line = sda_c & ~sda_oe;

  i2c_regfile_target #(.NREG(N), .SYNC_STAGES(2)) dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .dev_addr_i (DEV),
    .scl_i      (scl_c),
    .sda_i      (sda_line),
    .sda_oe_o   (sda_oe),
    .regs_o     (regs),
    .led_n_o    (led_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      logic [N*8-1:0] flat;
      for (int k = 0; k < N; k++) flat[k*8 +: 8] = m_reg[k];
      if (!hold) begin
        total++;
        if (regs !== flat) begin
          bad++;
          $display("FAIL R4 R5 R10 regs act=%h exp=%h", regs, flat);
        end
        total++;
        if (led_n !== ~m_reg[0][0]) begin
          bad++;
          $display("FAIL R11 led_n act=%0b exp=%0b", led_n, ~m_reg[0][0]);
        end
      end
      if (sda_oe !== prev_oe) begin
        total++;
        if (scl_c) begin
          bad++;
          $display("FAIL R12 sda drive moved with scl high act=%0b exp=%0b", sda_oe, prev_oe);
        end
      end
      prev_oe = sda_oe;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic bus_start();
    if (!scl_c) begin
      sda_c <= 1'b1; tick(Q);
      scl_c <= 1'b1; tick(Q);
    end
    sda_c <= 1'b0; tick(Q);
    scl_c <= 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_c <= 1'b0; tick(Q);
    scl_c <= 1'b1; tick(Q);
    sda_c <= 1'b1; tick(2 * Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n, input bit mark);
    for (int i = 7; i > 7 - n; i--) begin
      sda_c <= b[i]; tick(Q);
      if (mark && i == 0) hold = 1'b1;
      scl_c <= 1'b1; tick(2 * Q);
      scl_c <= 1'b0; tick(Q);
    end
  endtask

  task automatic model_match(input logic [7:0] b);
    if (b[7:1] == DEV) begin
      m_sel = 1; m_first = 1; m_pos = m_off;
    end else begin
      m_sel = 0;
    end
  endtask

  task automatic model_write(input logic [7:0] b);
    if (!m_sel) return;
    if (m_first) begin
      m_off = b; m_pos = b; m_first = 0;
    end else if (m_pos < N) begin
      m_reg[m_pos] = b; m_pos++;
    end
  endtask

  task automatic wr_byte(input logic [7:0] b, input bit is_addr, input string req);
    bit exp_ack;
    bit got_ack;
    exp_ack = is_addr ? (b[7:1] == DEV) : m_sel;
    send_bits(b, 8, 1'b1);
    if (is_addr) model_match(b);
    else model_write(b);
    hold = 1'b0;
    sda_c <= 1'b1; tick(Q);
    scl_c <= 1'b1; tick(Q);
    @(negedge clk);
    got_ack = ~sda_line;
    tick(Q);
    scl_c <= 1'b0; tick(Q);
    chk(got_ack == exp_ack, req, int'(got_ack), int'(exp_ack));
  endtask

  task automatic rd_byte(input bit give_ack, input string req);
    logic [7:0] exp;
    logic [7:0] got;
    exp = (m_pos < N) ? m_reg[m_pos] : 8'h00;
    if (m_pos < N) m_pos++;
    for (int i = 7; i >= 0; i--) begin
      sda_c <= 1'b1; tick(Q);
      scl_c <= 1'b1; tick(Q);
      @(negedge clk);
      got[i] = sda_line;
      tick(Q);
      scl_c <= 1'b0; tick(Q);
    end
    chk(got == exp, req, int'(got), int'(exp));
    sda_c <= give_ack ? 1'b0 : 1'b1; tick(Q);
    scl_c <= 1'b1; tick(2 * Q);
    scl_c <= 1'b0; tick(Q);
    sda_c <= 1'b1;
  endtask

  task automatic quiet_clocks(input int n);
    for (int i = 0; i < n; i++) begin
      sda_c <= 1'b1; tick(Q);
      scl_c <= 1'b1; tick(Q);
      @(negedge clk);
      chk(sda_oe == 1'b0, "R9 released after NACK", int'(sda_oe), 0);
      tick(Q);
      scl_c <= 1'b0; tick(Q);
    end
  endtask

  initial begin
    for (int k = 0; k < N; k++) m_reg[k] = 8'h00;
    tick(3);
    @(negedge clk);
    chk(sda_oe == 1'b0, "R1 sda released in reset", int'(sda_oe), 0);
    chk(regs == '0, "R1 regs zero in reset", int'(regs[31:0]), 0);
    rst_n = 1'b1;
    tick(4);
    @(negedge clk);
    chk(led_n == 1'b1, "R1 led_n idle", int'(led_n), 1);

    // R3 R4: pointer then consecutive writes
    bus_start();
    wr_byte({DEV, 1'b0}, 1, "R2 own address ack");
    wr_byte(8'h00, 0, "R3 pointer ack");
    wr_byte(8'h01, 0, "R4 data ack");
    wr_byte(8'hA5, 0, "R4 data ack");
    wr_byte(8'h3C, 0, "R4 data ack");
    bus_stop();
    @(negedge clk);
    chk(led_n == 1'b0, "R11 led on", int'(led_n), 0);

    // R8 R6: new read rewinds to stored pointer
    bus_start();
    wr_byte({DEV, 1'b1}, 1, "R2 read address ack");
    rd_byte(1, "R6 R8 read reg0");
    rd_byte(1, "R6 read reg1");
    rd_byte(0, "R6 read reg2");
    bus_stop();

    // R5: writes run off the end
    bus_start();
    wr_byte({DEV, 1'b0}, 1, "R2 address ack");
    wr_byte(8'h06, 0, "R3 pointer ack");
    wr_byte(8'h77, 0, "R4 reg6 ack");
    wr_byte(8'h88, 0, "R4 reg7 ack");
    wr_byte(8'h99, 0, "R5 dead zone ack");
    wr_byte(8'h55, 0, "R5 dead zone ack");
    bus_stop();

    // R7 R8 R9: pointer, repeated START, read past end, NACK
    bus_start();
    wr_byte({DEV, 1'b0}, 1, "R2 address ack");
    wr_byte(8'h05, 0, "R3 pointer ack");
    bus_start();
    wr_byte({DEV, 1'b1}, 1, "R8 repeated start ack");
    rd_byte(1, "R8 read reg5");
    rd_byte(1, "R6 read reg6");
    rd_byte(1, "R6 read reg7");
    rd_byte(1, "R7 zero past end");
    rd_byte(0, "R7 zero past end");
    quiet_clocks(9);
    bus_stop();

    // R2: foreign address ignored
    bus_start();
    wr_byte({7'h2A, 1'b0}, 1, "R2 foreign address nack");
    wr_byte(8'h00, 0, "R2 ignored byte nack");
    wr_byte(8'hFF, 0, "R2 ignored byte nack");
    bus_stop();

    // R10: STOP inside a byte
    bus_start();
    wr_byte({DEV, 1'b0}, 1, "R2 address ack");
    wr_byte(8'h01, 0, "R3 pointer ack");
    send_bits(8'hF0, 4, 1'b0);
    bus_stop();

    // R10: START inside a byte, then read from stored pointer
    bus_start();
    wr_byte({DEV, 1'b0}, 1, "R2 address ack");
    wr_byte(8'h02, 0, "R3 pointer ack");
    wr_byte(8'h11, 0, "R4 reg2 ack");
    send_bits(8'hEE, 3, 1'b0);
    bus_start();
    wr_byte({DEV, 1'b1}, 1, "R8 address ack");
    rd_byte(1, "R10 R8 read reg2");
    rd_byte(0, "R10 read reg3");
    bus_stop();

    // R11: clear indicator bit
    bus_start();
    wr_byte({DEV, 1'b0}, 1, "R2 address ack");
    wr_byte(8'h00, 0, "R3 pointer ack");
    wr_byte(8'hFE, 0, "R4 reg0 ack");
    bus_stop();
    @(negedge clk);
    chk(led_n == 1'b1, "R11 led off", int'(led_n), 1);

    tick(20);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule